// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block sequences a memory device into and out of its low-power states. An active-low sleep pin is the main control. While that pin is low, the block holds the device either in partial-array refresh or in deep power-down. A stored mode bit chooses between the two. In deep power-down every refresh request stops and the stored contents are treated as lost. Leaving deep power-down passes through an initialisation phase. During that phase the device reports busy and refuses every access, and the phase lasts for a fixed time counted in clock cycles.

The mode bit is written through two paths. A configuration write that arrives through the sleep-pin access path may set the bit either way. A software configuration write may only confirm partial-array refresh. When it does, that write also locks out pin-initiated entry into partial refresh. A data-valid flag tracks whether the array holds meaningful contents. A host write sets it, and entry into deep power-down clears it.

Top module: `lp_sleep_ctrl`

## Requirements
- R1: After reset the controller is awake (pwr_state = 0), refresh_en = 1, busy = 0, data_valid = 0, mode_par = 1 and sw_lock = 0.
- R2: With mode_par = 1 and sw_lock = 0, a low sleep_n moves pwr_state from 0 (awake) to 1 (partial refresh) with refresh_en = 1 and busy = 0. A high sleep_n then returns it directly to 0, and busy stays low the whole time.
- R3: With mode_par = 0, a low sleep_n moves pwr_state from 0 to 2 (deep power-down). In that state refresh_en = 0 and data_valid = 0.
- R4: A high sleep_n in state 2 moves pwr_state to 3 (initialising). busy is then high for exactly ceil(CLK_HZ * INIT_US / 1e6) consecutive cycles with refresh_en = 1, after which pwr_state returns to 0.
- R5: A software write (cfg_sw_wr = 1, cfg_mode = 1) accepted while mode_par = 1 sets sw_lock = 1. While sw_lock = 1, a low sleep_n leaves pwr_state at 0.
- R6: A software write never changes mode_par. A software write with cfg_mode = 0, or any software write while mode_par = 0, leaves mode_par and sw_lock unchanged.
- R7: A pin-path write (cfg_pin_wr = 1) loads mode_par from cfg_mode and clears sw_lock. It takes priority over a software write in the same cycle.
- R8: data_valid sets on a host_wr accepted in state 0. A host_wr in any other state is ignored.
- R9: Changes on sleep_n during state 3 are ignored until initialisation completes. If sleep_n is low when it completes and mode_par = 0, the controller re-enters state 2.
- R10: Configuration writes from either path are accepted only in state 0. In states 1, 2 and 3 they leave mode_par and sw_lock unchanged.
- R11: sleep_n passes through SYNC_STAGES synchronising registers. A change first affects pwr_state on the (SYNC_STAGES + 1)th rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_n | input | 1 | Active-low sleep request pin |
| cfg_sw_wr | input | 1 | Software configuration write strobe |
| cfg_pin_wr | input | 1 | Pin-path configuration write strobe |
| cfg_mode | input | 1 | Mode bit written: 1 = partial refresh, 0 = deep power-down |
| host_wr | input | 1 | Host data write strobe |
| refresh_en | output | 1 | Refresh allowed to run |
| busy | output | 1 | Initialisation in progress, accesses refused |
| data_valid | output | 1 | Array contents are meaningful |
| pwr_state | output | 2 | 0 awake, 1 partial refresh, 2 deep power-down, 3 initialising |
| mode_par | output | 1 | Current sleep mode bit |
| sw_lock | output | 1 | Software has locked out pin-initiated partial refresh |

## Verification
The bench builds the controller with CLK_HZ = 100000 and INIT_US = 150. This shrinks the initialisation to 15 cycles, so the busy window can be counted cycle by cycle and a sleep_n change can be placed inside it. SYNC_STAGES keeps its default of 2. As a result, the exact edge on which a pin change reaches pwr_state is checked, and so is the hazard of changing the mode while a stale low pin level is still in the synchroniser.

// File: rtl/lpsc_pkg.sv
`timescale 1ns/1ps
package lpsc_pkg;
   typedef enum logic [1:0] {
      PS_AWAKE = 2'd0,
      PS_PAR   = 2'd1,
      PS_DPD   = 2'd2,
      PS_INIT  = 2'd3
   } pwr_state_e;
endpackage

// File: rtl/lpsc_sync.sv
`timescale 1ns/1ps
// Synchroniser for the sleep pin; idles high (awake) during reset.
module lpsc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            r <= '1;
         end else begin
            r[0] <= d;
            for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
         end
      end
      assign q = r[STAGES-1];
   end
endmodule

// File: rtl/lpsc_cfg.sv
`timescale 1ns/1ps
// Sleep mode bit and software lock; writes accepted only when allowed.
module lpsc_cfg (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic sw_wr,
   input  logic pin_wr,
   input  logic wr_mode,
   output logic mode_par,
   output logic sw_lock
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_par <= 1'b1;
         sw_lock  <= 1'b0;
      end else if (accept) begin
         if (pin_wr) begin
            mode_par <= wr_mode;
            sw_lock  <= 1'b0;
         end else if (sw_wr && wr_mode && mode_par) begin
            sw_lock  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/lpsc_fsm.sv
`timescale 1ns/1ps
// Power state sequencer with initialisation countdown and data-valid flag.
module lpsc_fsm
   import lpsc_pkg::*;
#(
   parameter int INIT_CYC = 30000,
   localparam int CW = $clog2(INIT_CYC)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_n_s,
   input  logic       mode_par,
   input  logic       sw_lock,
   input  logic       host_wr,
   output pwr_state_e state,
   output logic       data_valid
);
   pwr_state_e       nxt;
   logic [CW-1:0]    cnt;

   always_comb begin
      nxt = state;
      unique case (state)
         PS_AWAKE: if (!sleep_n_s) begin
            if (!mode_par)      nxt = PS_DPD;
            else if (!sw_lock)  nxt = PS_PAR;
         end
         PS_PAR:   if (sleep_n_s) nxt = PS_AWAKE;
         PS_DPD:   if (sleep_n_s) nxt = PS_INIT;
         PS_INIT:  if (cnt == '0) nxt = PS_AWAKE;
         default:  nxt = PS_AWAKE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= PS_AWAKE;
         cnt        <= '0;
         data_valid <= 1'b0;
      end else begin
         state <= nxt;
         if (state == PS_DPD && nxt == PS_INIT)
            cnt <= CW'(INIT_CYC - 1);
         else if (state == PS_INIT && cnt != '0)
            cnt <= cnt - 1'b1;
         if (nxt == PS_DPD)
            data_valid <= 1'b0;
         else if (state == PS_AWAKE && host_wr)
            data_valid <= 1'b1;
      end
   end
endmodule

// File: rtl/lp_sleep_ctrl.sv
`timescale 1ns/1ps
module lp_sleep_ctrl
   import lpsc_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 200_000_000,
   parameter int unsigned INIT_US     = 150,
   parameter int          SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_n,
   input  logic       cfg_sw_wr,
   input  logic       cfg_pin_wr,
   input  logic       cfg_mode,
   input  logic       host_wr,
   output logic       refresh_en,
   output logic       busy,
   output logic       data_valid,
   output logic [1:0] pwr_state,
   output logic       mode_par,
   output logic       sw_lock
);
   localparam longint unsigned CYC_L =
      (64'(CLK_HZ) * 64'(INIT_US) + 64'd999_999) / 64'd1_000_000;
   localparam int INIT_CYC = int'(CYC_L);

   if (INIT_CYC < 2) begin : g_bad_cyc
      $error("lp_sleep_ctrl: initialisation must span at least two cycles");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("lp_sleep_ctrl: SYNC_STAGES out of range 0..4");
   end

   logic       sleep_s;
   pwr_state_e st;

   lpsc_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(sleep_n), .q(sleep_s)
   );

   lpsc_cfg cfg_i (
      .clk(clk), .rst_n(rst_n), .accept(st == PS_AWAKE),
      .sw_wr(cfg_sw_wr), .pin_wr(cfg_pin_wr), .wr_mode(cfg_mode),
      .mode_par(mode_par), .sw_lock(sw_lock)
   );

   lpsc_fsm #(.INIT_CYC(INIT_CYC)) fsm_i (
      .clk(clk), .rst_n(rst_n), .sleep_n_s(sleep_s),
      .mode_par(mode_par), .sw_lock(sw_lock), .host_wr(host_wr),
      .state(st), .data_valid(data_valid)
   );

   assign pwr_state  = st;
   assign refresh_en = (st != PS_DPD);
   assign busy       = (st == PS_INIT);
endmodule

// File: rtl/lpsc_chk.sv
`timescale 1ns/1ps
module lpsc_chk #(
   parameter int INIT_CYC = 30000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_pin_wr,
   input logic       host_wr,
   input logic       refresh_en,
   input logic       busy,
   input logic       data_valid,
   input logic [1:0] pwr_state,
   input logic       mode_par
);
   int unsigned run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)    run_q <= 0;
      else if (busy) run_q <= run_q + 1;
      else           run_q <= 0;
   end

   // R3
   dpd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd2) |-> (!refresh_en && !data_valid));
   // R4
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == INIT_CYC));
   // R4
   dpd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_state) == 2'd2 && pwr_state != 2'd2) |-> (pwr_state == 2'd3));
   // R2
   par_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_state) == 2'd1 && pwr_state != 2'd1) |-> (pwr_state == 2'd0));
   // R9
   init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd3) |=> (pwr_state == 2'd3 || pwr_state == 2'd0));
   // R6
   mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mode_par) |-> $past(cfg_pin_wr));
   // R8
   valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_valid) |-> ($past(host_wr) && $past(pwr_state) == 2'd0));
endmodule

bind lp_sleep_ctrl lpsc_chk #(.INIT_CYC(INIT_CYC)) chk_i (
   .clk(clk), .rst_n(rst_n), .cfg_pin_wr(cfg_pin_wr), .host_wr(host_wr),
   .refresh_en(refresh_en), .busy(busy), .data_valid(data_valid),
   .pwr_state(pwr_state), .mode_par(mode_par)
);

// File: tb/lp_sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module lp_sleep_ctrl_tb_top;
   localparam int INIT_N = 15;   // 100 kHz * 150 us

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_n = 1'b1, cfg_sw_wr = 1'b0, cfg_pin_wr = 1'b0, cfg_mode = 1'b0, host_wr = 1'b0;
   logic refresh_en, busy, data_valid, mode_par, sw_lock;
   logic [1:0] pwr_state;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lp_sleep_ctrl #(.CLK_HZ(100_000), .INIT_US(150), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .cfg_sw_wr(cfg_sw_wr),
      .cfg_pin_wr(cfg_pin_wr), .cfg_mode(cfg_mode), .host_wr(host_wr),
      .refresh_en(refresh_en), .busy(busy), .data_valid(data_valid),
      .pwr_state(pwr_state), .mode_par(mode_par), .sw_lock(sw_lock)
   );

   typedef struct packed {
      logic sl; logic sw; logic pw; logic md; logic hw;
      logic [7:0] wt;
      logic [1:0] st; logic rf; logic by; logic dv; logic mp; logic lk;
      logic [3:0] rq;
   } vec_t;

   localparam vec_t VECS [14] = '{
      '{1'b1,1'b0,1'b0,1'b0,1'b1, 8'd0, 2'd0,1'b1,1'b0,1'b1,1'b1,1'b0, 4'd8},  // R8 host write
      '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd3, 2'd1,1'b1,1'b0,1'b1,1'b1,1'b0, 4'd2},  // R2 enter partial
      '{1'b0,1'b1,1'b0,1'b1,1'b0, 8'd1, 2'd1,1'b1,1'b0,1'b1,1'b1,1'b0, 4'd10}, // R10 sw write refused
      '{1'b1,1'b0,1'b0,1'b0,1'b0, 8'd3, 2'd0,1'b1,1'b0,1'b1,1'b1,1'b0, 4'd2},  // R2 direct wake
      '{1'b1,1'b1,1'b0,1'b0,1'b0, 8'd0, 2'd0,1'b1,1'b0,1'b1,1'b1,1'b0, 4'd6},  // R6 sw deselect ignored
      '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd0, 2'd0,1'b1,1'b0,1'b1,1'b1,1'b1, 4'd5},  // R5 sw lock
      '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd4, 2'd0,1'b1,1'b0,1'b1,1'b1,1'b1, 4'd5},  // R5 pin blocked
      '{1'b1,1'b0,1'b0,1'b0,1'b0, 8'd3, 2'd0,1'b1,1'b0,1'b1,1'b1,1'b1, 4'd5},  // R5 pin released
      '{1'b1,1'b0,1'b1,1'b0,1'b0, 8'd0, 2'd0,1'b1,1'b0,1'b1,1'b0,1'b0, 4'd7},  // R7 pin-path write
      '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd0, 2'd0,1'b1,1'b0,1'b1,1'b0,1'b0, 4'd6},  // R6 sw select ignored
      '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd3, 2'd2,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3 deep power-down
      '{1'b0,1'b0,1'b0,1'b0,1'b1, 8'd1, 2'd2,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd8},  // R8 write refused
      '{1'b1,1'b0,1'b0,1'b0,1'b0, 8'd3, 2'd3,1'b1,1'b1,1'b0,1'b0,1'b0, 4'd4},  // R4 initialising
      '{1'b1,1'b0,1'b0,1'b0,1'b0, 8'd20,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0, 4'd4}   // R4 back awake
   };

   task automatic check(input int rq, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      sleep_n = v.sl; cfg_sw_wr = v.sw; cfg_pin_wr = v.pw; cfg_mode = v.md; host_wr = v.hw;
      @(negedge clk);
      cfg_sw_wr = 1'b0; cfg_pin_wr = 1'b0; host_wr = 1'b0;
      repeat (int'(v.wt)) @(negedge clk);
   endtask

   task automatic check_all(input vec_t v);
      check(int'(v.rq), "pwr_state",  int'(pwr_state),  int'(v.st));
      check(int'(v.rq), "refresh_en", int'(refresh_en), int'(v.rf));
      check(int'(v.rq), "busy",       int'(busy),       int'(v.by));
      check(int'(v.rq), "data_valid", int'(data_valid), int'(v.dv));
      check(int'(v.rq), "mode_par",   int'(mode_par),   int'(v.mp));
      check(int'(v.rq), "sw_lock",    int'(sw_lock),    int'(v.lk));
   endtask

   initial begin
      int nb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(1, "pwr_state",  int'(pwr_state), 0);
      check(1, "refresh_en", int'(refresh_en), 1);
      check(1, "busy",       int'(busy), 0);
      check(1, "data_valid", int'(data_valid), 0);
      check(1, "mode_par",   int'(mode_par), 1);
      check(1, "sw_lock",    int'(sw_lock), 0);

      foreach (VECS[i]) begin
         apply(VECS[i]);
         check_all(VECS[i]);
      end

      // R9: pin drops mid-initialisation; busy window stays whole, then re-sleep
      @(negedge clk); sleep_n = 1'b0;
      repeat (4) @(negedge clk);
      check(3, "pwr_state", int'(pwr_state), 2);
      sleep_n = 1'b1;
      nb = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (busy) nb++;
         if (i == 6) sleep_n = 1'b0;
      end
      check(4, "busy cycles", nb, INIT_N);
      check(9, "pwr_state after init", int'(pwr_state), 2);
      sleep_n = 1'b1;
      repeat (25) @(negedge clk);
      check(9, "pwr_state awake", int'(pwr_state), 0);

      // R11: pin change reaches pwr_state on the third edge
      cfg_pin_wr = 1'b1; cfg_mode = 1'b1;
      @(negedge clk); cfg_pin_wr = 1'b0;
      check(7, "mode_par", int'(mode_par), 1);
      sleep_n = 1'b0;
      repeat (2) @(negedge clk);
      check(11, "pwr_state edge2", int'(pwr_state), 0);
      @(negedge clk);
      check(11, "pwr_state edge3", int'(pwr_state), 1);
      sleep_n = 1'b1;
      repeat (4) @(negedge clk);
      check(2, "pwr_state woke", int'(pwr_state), 0);
      check(2, "busy", int'(busy), 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule